// File: doc/BRIEF.md
# Raster-Line Video Bus Access Scheduler

This block decides, for every bus cycle of a raster line, who owns each of the two bus phases of a character-based video controller that shares its memory with a CPU. Phase A belongs to the video side and carries character/bitmap fetches, refresh, sprite pointer reads, sprite data reads or idle accesses. Phase B normally belongs to the CPU. The video side takes phase B for screen-matrix/colour fetches on bad lines and for the data reads of sprites that are active.

The caller supplies the cycle position within the line (1 to the line length), the raster line number, the vertical scroll value, a display-enable flag, eight sprite-active flags and a mode bit that selects the short or the long line. The block returns a registered access code and a slot index for each phase: the display column for matrix and character fetches, or the sprite number for sprite slots. Sprite slots sit at fixed positions and wrap from the end of the line into its start.

Top module: `raster_bus_sched`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, a_kind is IDLE, b_kind is CPU and both indexes are 0.
- R2: Outputs are registered with one cycle of latency, using the codes CPU=0, GFX=1, MTX=2, SPTR=3, SDAT=4, REF=5, IDLE=6.
- R3: The line length is 63 cycles when ntsc is 0 and 65 cycles when ntsc is 1; all wrapping uses that length.
- R4: In cycles 16 to 55, phase A carries GFX with index cyc-16 (columns 0 to 39).
- R5: A bad line is one with den high, line within 48 to 247 inclusive and line[2:0] equal to yscroll; in cycles 16 to 55 of a bad line, phase B carries MTX with the same column as phase A, and on any other line phase B there is CPU.
- R6: In cycles 11 to 15, phase A carries REF with index 0, and phase B is CPU.
- R7: The pointer read of sprite n sits in phase A of cycle ((L-6+2n) mod L)+1 (short line: 58, 60, 62, 1, 3, 5, 7, 9), index n, whether or not the sprite is active.
- R8: For an active sprite n, phase B of its pointer cycle and both phases of the following cycle (cycle 1 after cycle L) carry SDAT with index n.
- R9: For an inactive sprite, its phase A data slot is IDLE and its phase B data slots are CPU, both with index 0.
- R10: Every other phase A slot is IDLE and every other phase B slot is CPU, with index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntsc | input | 1 | 0 selects the 63-cycle line, 1 the 65-cycle line |
| cyc | input | 7 | Cycle within the line, 1 to the line length |
| line | input | 9 | Raster line number |
| yscroll | input | 3 | Vertical scroll value |
| den | input | 1 | Display enable |
| spr_act | input | 8 | Sprite-active flags, bit n for sprite n |
| a_kind | output | 3 | Access code for phase A |
| a_idx | output | 6 | Column or sprite index for phase A |
| b_kind | output | 3 | Access code for phase B |
| b_idx | output | 6 | Column or sprite index for phase B |

## Verification
The two functions that meet in one cycle are the sprite data read in phase B and the CPU's ownership of that phase, at the pointer cycle and at the cycle after it, including the pair that wraps from the last cycle of the line into cycle 1. The bench sweeps every cycle of both line lengths with all sprites active, none active and a mixed pattern, so the same slot is seen once taken from the CPU and once handed back. Bad-line conditions are swept across band edges, scroll mismatch and display disable, and each phase is judged against a schedule the bench derives from an offset into the sprite region rather than from the pointer cycle formula.

// File: rtl/raster_bus_sched.sv
module raster_bus_sched #(
  parameter int LINE_A    = 63,
  parameter int LINE_B    = 65,
  parameter int WIN_START = 16,
  parameter int COLS      = 40,
  parameter int NSPR      = 8,
  parameter int REF_SLOTS = 5,
  parameter int BAND_TOP  = 48,
  parameter int BAND_BOT  = 247
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ntsc,
  input  logic [6:0] cyc,
  input  logic [8:0] line,
  input  logic [2:0] yscroll,
  input  logic       den,
  input  logic [7:0] spr_act,
  output logic [2:0] a_kind,
  output logic [5:0] a_idx,
  output logic [2:0] b_kind,
  output logic [5:0] b_idx
);
  localparam int WIN_END   = WIN_START + COLS - 1;
  localparam int REF_START = WIN_START - REF_SLOTS;

  localparam logic [2:0] K_CPU  = 3'd0;
  localparam logic [2:0] K_GFX  = 3'd1;
  localparam logic [2:0] K_MTX  = 3'd2;
  localparam logic [2:0] K_SPTR = 3'd3;
  localparam logic [2:0] K_SDAT = 3'd4;
  localparam logic [2:0] K_REF  = 3'd5;
  localparam logic [2:0] K_IDLE = 3'd6;

  logic       bad;
  logic [2:0] na_kind, nb_kind;
  logic [5:0] na_idx, nb_idx;

  assign bad = den && (int'(line) >= BAND_TOP) && (int'(line) <= BAND_BOT)
               && (line[2:0] == yscroll);

  always_comb begin
    int len, c, pc, nc;
    len = ntsc ? LINE_B : LINE_A;
    c   = int'(cyc);
    na_kind = K_IDLE; na_idx = '0;
    nb_kind = K_CPU;  nb_idx = '0;
    if (c >= REF_START && c < WIN_START) begin
      na_kind = K_REF;
    end else if (c >= WIN_START && c <= WIN_END) begin
      na_kind = K_GFX;
      na_idx  = 6'(c - WIN_START);
      if (bad) begin
        nb_kind = K_MTX;
        nb_idx  = 6'(c - WIN_START);
      end
    end
    for (int n = 0; n < NSPR; n++) begin
      pc = ((len - 6 + 2 * n) % len) + 1;
      nc = (pc == len) ? 1 : pc + 1;
      if (c == pc) begin
        na_kind = K_SPTR;
        na_idx  = 6'(n);
        if (spr_act[n]) begin
          nb_kind = K_SDAT;
          nb_idx  = 6'(n);
        end
      end else if (c == nc && spr_act[n]) begin
        na_kind = K_SDAT; na_idx = 6'(n);
        nb_kind = K_SDAT; nb_idx = 6'(n);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_kind <= K_IDLE; a_idx <= '0;
      b_kind <= K_CPU;  b_idx <= '0;
    end else begin
      a_kind <= na_kind; a_idx <= na_idx;
      b_kind <= nb_kind; b_idx <= nb_idx;
    end
  end
endmodule

// File: rtl/raster_bus_sched_chk.sv
module raster_bus_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] cyc,
  input logic [8:0] line,
  input logic [2:0] yscroll,
  input logic       den,
  input logic [7:0] spr_act,
  input logic [2:0] a_kind,
  input logic [5:0] a_idx,
  input logic [2:0] b_kind,
  input logic [5:0] b_idx
);
  // R10
  a_never_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_kind != 3'd0);

  // R5
  mtx_pairs_gfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_kind == 3'd2) |-> (a_kind == 3'd1 && a_idx == b_idx));

  // R5
  mtx_needs_badline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_kind == 3'd2) |-> $past(den && line[2:0] == yscroll));

  // R6
  ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_kind == 3'd5) |-> ($past(cyc) >= 7'd11 && $past(cyc) <= 7'd15));

  // R4
  gfx_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_kind == 3'd1) |-> (a_idx == 6'($past(cyc) - 7'd16)));

  // R8
  sdat_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_kind == 3'd4) |-> (b_idx < 6'd8 && $past(spr_act[b_idx[2:0]])));
endmodule

bind raster_bus_sched raster_bus_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc(cyc), .line(line), .yscroll(yscroll),
  .den(den), .spr_act(spr_act), .a_kind(a_kind), .a_idx(a_idx),
  .b_kind(b_kind), .b_idx(b_idx)
);

// File: tb/tb_raster_bus_sched.sv
module tb_raster_bus_sched;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ntsc = 0;
  logic [6:0] cyc = 7'd1;
  logic [8:0] line = '0;
  logic [2:0] yscroll = '0;
  logic       den = 0;
  logic [7:0] spr_act = '0;
  logic [2:0] a_kind, b_kind;
  logic [5:0] a_idx, b_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  raster_bus_sched dut (
    .clk(clk), .rst_n(rst_n), .ntsc(ntsc), .cyc(cyc), .line(line),
    .yscroll(yscroll), .den(den), .spr_act(spr_act),
    .a_kind(a_kind), .a_idx(a_idx), .b_kind(b_kind), .b_idx(b_idx)
  );

  task automatic check(string req, int ak, int ai, int bk, int bi);
    checks++;
    if (int'(a_kind) != ak || int'(a_idx) != ai ||
        int'(b_kind) != bk || int'(b_idx) != bi) begin
      errors++;
      $display("FAIL %s cyc=%0d ntsc=%0d line=%0d act=%h: got a=%0d/%0d b=%0d/%0d exp a=%0d/%0d b=%0d/%0d",
               req, cyc, ntsc, line, spr_act, a_kind, a_idx, b_kind, b_idx,
               ak, ai, bk, bi);
    end
  endtask

  task automatic expect_slot(int len, int c, bit badl, logic [7:0] act,
                             output int ak, output int ai, output int bk,
                             output int bi, output string req);
    int o, s;
    ak = 6; ai = 0; bk = 0; bi = 0; req = "R10";
    o = (c - (len - 5) + len) % len;
    if (o < 16) begin
      s = o / 2;
      if (o % 2 == 0) begin
        ak = 3; ai = s; req = "R7";
        if (act[s]) begin bk = 4; bi = s; req = "R8"; end
        else req = "R9";
      end else if (act[s]) begin
        ak = 4; ai = s; bk = 4; bi = s; req = "R8";
      end else req = "R9";
    end else if (c >= 11 && c <= 15) begin
      ak = 5; req = "R6";
    end else if (c >= 16 && c <= 55) begin
      ak = 1; ai = c - 16; req = "R4";
      if (badl) begin bk = 2; bi = c - 16; req = "R5"; end
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ak, ai, bk, bi;
    string req;
    int lines[6] = '{51, 52, 51, 3, 247, 248};
    int scr[6]   = '{3, 3, 3, 3, 7, 0};
    bit dens[6]  = '{1, 1, 0, 1, 1, 1};
    bit bads[6]  = '{1, 0, 0, 0, 1, 0};
    logic [7:0] acts[3] = '{8'hFF, 8'h00, 8'hA5};

    // R1: reset state, with inputs that would otherwise produce a GFX slot
    cyc = 7'd20; den = 1; line = 9'd51; yscroll = 3'd3; spr_act = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 6, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      int len;
      len = (m == 0) ? 63 : 65;  // R3
      for (int li = 0; li < 6; li++) begin
        for (int ai2 = 0; ai2 < 3; ai2++) begin
          for (int c = 1; c <= len; c++) begin
            ntsc = m[0]; line = 9'(lines[li]); yscroll = 3'(scr[li]);
            den = dens[li]; spr_act = acts[ai2]; cyc = 7'(c);
            @(posedge clk);
            @(negedge clk);
            // R2: one cycle latency, R3: wrap uses this line length
            expect_slot(len, c, bads[li], acts[ai2], ak, ai, bk, bi, req);
            check(req, ak, ai, bk, bi);
          end
        end
      end
    end

    // R1: reset reasserted mid-schedule returns outputs to reset values
    cyc = 7'd16; line = 9'd51; yscroll = 3'd3; den = 1; ntsc = 0;
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    check("R1", 6, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule